// File: doc/BRIEF.md
# Precision-Time Event Frame Classifier

This block watches the receive byte stream of an Ethernet port and decides, while the frame is still arriving, whether it carries a precision-time-protocol event message. When it decides yes, it pulses a one-cycle strobe that tells the neighbouring capture register to latch the receive time. Bytes arrive one per accepted cycle (`in_valid`), and the first byte of each frame is flagged with `in_sof`. Byte 0 is the first destination-address byte, and the Ethertype sits at bytes 12 and 13. VLAN tags are not expected.

Configuration inputs select one of four filter modes (2-bit code: 0 = off, 1 = version-1 over UDP, 2 = version-2 events, 3 = every frame). They also select the version-1 message to match, and enable the layer-2 path, the layer-4 path and a UDP source-port check. The block follows IPv4 option length through the header-length field to locate the UDP header. It compares the ports and then inspects the first bytes of the time-protocol payload. The decision is made on one particular byte, and the strobe is registered. It therefore rises in the cycle after that byte is accepted and never repeats within a frame.

Top module: `ptp_event_classifier`

## Requirements
- R1: While reset is high and in the first cycle after it, `ts_event` is low.
- R2: With `cfg_mode` = 0, no frame ever produces `ts_event`.
- R3: With `cfg_mode` = 3, `ts_event` is high in the cycle after the start-of-frame byte is accepted, whatever the frame holds.
- R4: A layer-2 time frame has Ethertype 0x88F7 in bytes 12 (0x88) and 13 (0xF7), with its payload from byte 14. In mode 2 with `cfg_l2_en` = 1, an event message strobes one cycle after payload byte 1 (frame byte 15). An event message has a type 0..3 in the low nibble of payload byte 0 and the value 2 in the low nibble of payload byte 1. With `cfg_l2_en` = 0, the same frame does not strobe.
- R5: An IPv4/UDP time frame has Ethertype 0x0800, header version 4 in the high nibble of byte 14, protocol 17 at IP header byte 9 (frame byte 23) and UDP destination port 319. In mode 2 with `cfg_l4_en` = 1, an event message in its UDP payload strobes one cycle after payload byte 1. With `cfg_l4_en` = 0, it does not strobe.
- R6: The UDP header starts at frame byte 14 + 4×IHL, where IHL is the low nibble of byte 14. The time payload follows 8 bytes later, so IP options move the decision point.
- R7: With `cfg_src_chk` = 1, a UDP frame also needs source port 319 to strobe. With `cfg_src_chk` = 0, the source port is not compared.
- R8: In mode 2, a message type of 4 or above, or a version nibble other than 2, gives no strobe.
- R9: In mode 1, only layer-4 frames with version nibble 1 (payload byte 1) qualify. They strobe one cycle after payload byte 32 when that byte equals the selected control value: 0 for Sync (`cfg_v1_dreq` = 0), 1 for Delay_Req (`cfg_v1_dreq` = 1). Layer-2 frames never strobe in mode 1.
- R10: Cycles with `in_valid` low neither advance nor alter the parse. Each frame gives at most one strobe, and a new start-of-frame re-arms the block.
- R11: A UDP destination port other than 319, or an IP protocol other than 17, gives no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A byte is presented this cycle |
| in_sof | input | 1 | The presented byte is the first of a frame |
| in_data | input | 8 | Frame byte |
| cfg_mode | input | 2 | Filter mode: 0 off, 1 version-1 UDP, 2 version-2 events, 3 all frames |
| cfg_v1_dreq | input | 1 | Version-1 message select: 0 Sync, 1 Delay_Req |
| cfg_l2_en | input | 1 | Enable the Ethertype path |
| cfg_l4_en | input | 1 | Enable the IPv4/UDP path |
| cfg_src_chk | input | 1 | Also require UDP source port 319 |
| ts_event | output | 1 | One-cycle timestamp-event strobe |

## Verification
The hardest situation to reach is a decision byte that lies deep in the frame and whose position depends on an earlier field: the version-1 control byte behind IP options. The stimulus builds frames byte by byte with chosen header lengths, ports and payload bytes. It records after which accepted byte the strobe appeared, so a wrong offset shows up as a wrong index rather than only as a missing pulse. The same frames are also sent with idle cycles between bytes, which checks that the position counter advances only on accepted bytes.

// File: rtl/ptp_cls_pkg.sv
package ptp_cls_pkg;

  typedef enum logic [1:0] {
    FILT_OFF    = 2'd0,
    FILT_V1_UDP = 2'd1,
    FILT_V2_EVT = 2'd2,
    FILT_ALL    = 2'd3
  } filt_mode_e;

  localparam logic [15:0] ETYPE_PTP    = 16'h88F7;
  localparam logic [15:0] ETYPE_IPV4   = 16'h0800;
  localparam logic [7:0]  IPPROTO_UDP_C = 8'd17;
  localparam logic [15:0] PTP_EVT_PORT = 16'd319;
  localparam int          ETH_HDR_LEN  = 14;
  localparam int          UDP_HDR_LEN  = 8;
  localparam int          IP_PROTO_OFS = 9;

endpackage

// File: rtl/ptp_hdr_parser.sv
module ptp_hdr_parser
  import ptp_cls_pkg::*;
#(
  parameter int POS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic [7:0]       in_data,
  input  logic             cfg_src_chk,
  output logic             sof_byte_o,
  output logic             ptp_vld_o,
  output logic [POS_W-1:0] ptp_ofs_o,
  output logic             is_l2_o,
  output logic             is_l4_o
);

  localparam logic [POS_W-1:0] POS_MAX   = {POS_W{1'b1}};
  localparam logic [POS_W-1:0] P_ETH_HI  = POS_W'(12);
  localparam logic [POS_W-1:0] P_ETH_LO  = POS_W'(13);
  localparam logic [POS_W-1:0] P_PAYLOAD = POS_W'(ETH_HDR_LEN);
  localparam logic [POS_W-1:0] P_PROTO   = POS_W'(ETH_HDR_LEN + IP_PROTO_OFS);

  logic [POS_W-1:0] pos_q, pos_cur;
  logic             in_frame_q, frame_act, take;
  logic [15:0]      etype_q, src_q, dst_q;
  logic [3:0]       ipver_q, ihl_q;
  logic [7:0]       proto_q;
  logic [POS_W-1:0] udp_base, ptp_start;
  logic             l2_frame, l4_frame;

  assign pos_cur   = in_sof ? '0 : pos_q;
  assign frame_act = in_sof | in_frame_q;
  assign take      = in_valid & frame_act;

  assign udp_base  = P_PAYLOAD + POS_W'({ihl_q, 2'b00});
  assign ptp_start = udp_base + POS_W'(UDP_HDR_LEN);

  // byte position within the frame, advancing only on accepted bytes
  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q      <= '0;
      in_frame_q <= 1'b0;
    end else if (in_valid) begin
      if (in_sof) in_frame_q <= 1'b1;
      if (frame_act) pos_q <= (pos_cur == POS_MAX) ? pos_cur : pos_cur + 1'b1;
    end
  end

  // header field capture
  always_ff @(posedge clk) begin
    if (rst) begin
      etype_q <= '0;
      ipver_q <= '0;
      ihl_q   <= '0;
      proto_q <= '0;
      src_q   <= '0;
      dst_q   <= '0;
    end else if (take) begin
      if (in_sof) begin
        etype_q <= '0;
        ipver_q <= '0;
        ihl_q   <= '0;
        proto_q <= '0;
        src_q   <= '0;
        dst_q   <= '0;
      end else begin
        if (pos_cur == P_ETH_HI)  etype_q[15:8] <= in_data;
        if (pos_cur == P_ETH_LO)  etype_q[7:0]  <= in_data;
        if (pos_cur == P_PAYLOAD) begin
          ipver_q <= in_data[7:4];
          ihl_q   <= in_data[3:0];
        end
        if (pos_cur == P_PROTO)   proto_q <= in_data;
        if (pos_cur > P_PROTO) begin
          if (pos_cur == udp_base)          src_q[15:8] <= in_data;
          if (pos_cur == udp_base + 1'b1)   src_q[7:0]  <= in_data;
          if (pos_cur == udp_base + 2'd2)   dst_q[15:8] <= in_data;
          if (pos_cur == udp_base + 2'd3)   dst_q[7:0]  <= in_data;
        end
      end
    end
  end

  assign l2_frame = (etype_q == ETYPE_PTP);
  assign l4_frame = (etype_q == ETYPE_IPV4) && (ipver_q == 4'd4) && (ihl_q >= 4'd5) &&
                    (proto_q == IPPROTO_UDP_C) && (dst_q == PTP_EVT_PORT) &&
                    (!cfg_src_chk || (src_q == PTP_EVT_PORT));

  always_comb begin
    ptp_vld_o = 1'b0;
    ptp_ofs_o = '0;
    is_l2_o   = 1'b0;
    is_l4_o   = 1'b0;
    if (take && !in_sof) begin
      if (l2_frame && pos_cur >= P_PAYLOAD) begin
        ptp_vld_o = 1'b1;
        ptp_ofs_o = pos_cur - P_PAYLOAD;
        is_l2_o   = 1'b1;
      end else if (l4_frame && pos_cur >= ptp_start) begin
        ptp_vld_o = 1'b1;
        ptp_ofs_o = pos_cur - ptp_start;
        is_l4_o   = 1'b1;
      end
    end
  end

  assign sof_byte_o = in_valid & in_sof;

endmodule

// File: rtl/ptp_msg_matcher.sv
module ptp_msg_matcher
  import ptp_cls_pkg::*;
#(
  parameter int POS_W       = 8,
  parameter int V1_CTRL_OFS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  filt_mode_e       mode,
  input  logic             v1_dreq,
  input  logic             l2_en,
  input  logic             l4_en,
  input  logic             sof_byte,
  input  logic             ptp_vld,
  input  logic [POS_W-1:0] ptp_ofs,
  input  logic             is_l2,
  input  logic             is_l4,
  input  logic [7:0]       in_data,
  output logic             hit
);

  localparam logic [POS_W-1:0] OFS_TYPE = POS_W'(0);
  localparam logic [POS_W-1:0] OFS_VER  = POS_W'(1);
  localparam logic [POS_W-1:0] OFS_CTRL = POS_W'(V1_CTRL_OFS);
  localparam logic [3:0]       V2_NUM   = 4'd2;
  localparam logic [3:0]       V1_NUM   = 4'd1;
  localparam logic [3:0]       EVT_LIM  = 4'd4;

  logic [3:0] msg_q, pver_q;
  logic       path_ok;

  always_ff @(posedge clk) begin
    if (rst || sof_byte) begin
      msg_q  <= '1;
      pver_q <= '0;
    end else if (ptp_vld) begin
      if (ptp_ofs == OFS_TYPE) msg_q  <= in_data[3:0];
      if (ptp_ofs == OFS_VER)  pver_q <= in_data[3:0];
    end
  end

  assign path_ok = (is_l2 && l2_en) || (is_l4 && l4_en);

  always_comb begin
    hit = 1'b0;
    unique case (mode)
      FILT_ALL:    hit = sof_byte;
      FILT_V2_EVT: hit = ptp_vld && path_ok && (ptp_ofs == OFS_VER) &&
                         (in_data[3:0] == V2_NUM) && (msg_q < EVT_LIM);
      FILT_V1_UDP: hit = ptp_vld && is_l4 && l4_en && (ptp_ofs == OFS_CTRL) &&
                         (pver_q == V1_NUM) && (in_data == {7'b0, v1_dreq});
      default:     hit = 1'b0;
    endcase
  end

  assert_v1_udp_only_R9: assert property (@(posedge clk) disable iff (rst)
    (hit && mode == FILT_V1_UDP) |-> (is_l4 && l4_en));

endmodule

// File: rtl/ptp_evt_strobe.sv
module ptp_evt_strobe (
  input  logic clk,
  input  logic rst,
  input  logic sof_byte,
  input  logic hit,
  output logic ev_o
);

  logic fired_q, ev_q, armed;

  assign armed = sof_byte | ~fired_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fired_q <= 1'b0;
      ev_q    <= 1'b0;
    end else begin
      ev_q    <= hit & armed;
      fired_q <= sof_byte ? hit : (fired_q | hit);
    end
  end

  assign ev_o = ev_q;

  assert_once_per_frame_R10: assert property (@(posedge clk) disable iff (rst)
    ev_q |=> (!ev_q || $past(sof_byte)));

endmodule

// File: rtl/ptp_event_classifier.sv
module ptp_event_classifier
  import ptp_cls_pkg::*;
#(
  parameter int POS_W       = 8,
  parameter int V1_CTRL_OFS = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic       in_sof,
  input  logic [7:0] in_data,
  input  logic [1:0] cfg_mode,
  input  logic       cfg_v1_dreq,
  input  logic       cfg_l2_en,
  input  logic       cfg_l4_en,
  input  logic       cfg_src_chk,
  output logic       ts_event
);

  logic             sof_byte, ptp_vld, is_l2, is_l4, hit;
  logic [POS_W-1:0] ptp_ofs;

  ptp_hdr_parser #(.POS_W(POS_W)) u_parser (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_data(in_data),
    .cfg_src_chk(cfg_src_chk), .sof_byte_o(sof_byte), .ptp_vld_o(ptp_vld),
    .ptp_ofs_o(ptp_ofs), .is_l2_o(is_l2), .is_l4_o(is_l4)
  );

  ptp_msg_matcher #(.POS_W(POS_W), .V1_CTRL_OFS(V1_CTRL_OFS)) u_match (
    .clk(clk), .rst(rst), .mode(filt_mode_e'(cfg_mode)), .v1_dreq(cfg_v1_dreq),
    .l2_en(cfg_l2_en), .l4_en(cfg_l4_en), .sof_byte(sof_byte), .ptp_vld(ptp_vld),
    .ptp_ofs(ptp_ofs), .is_l2(is_l2), .is_l4(is_l4), .in_data(in_data), .hit(hit)
  );

  ptp_evt_strobe u_strobe (
    .clk(clk), .rst(rst), .sof_byte(sof_byte), .hit(hit), .ev_o(ts_event)
  );

  assert_off_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    ts_event |-> ($past(cfg_mode) != 2'd0));

  assert_all_sof_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_sof && cfg_mode == 2'd3) |=> ts_event);

  assert_byte_cause_R10: assert property (@(posedge clk) disable iff (rst)
    ts_event |-> $past(in_valid));

endmodule

// File: tb/ptp_event_classifier_tb.sv
`timescale 1ns/1ps
module ptp_event_classifier_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0, in_sof = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic [1:0] cfg_mode = 2'd0;
  logic       cfg_v1_dreq = 1'b0, cfg_l2_en = 1'b0, cfg_l4_en = 1'b0, cfg_src_chk = 1'b0;
  logic       ts_event;

  ptp_event_classifier u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_data(in_data),
    .cfg_mode(cfg_mode), .cfg_v1_dreq(cfg_v1_dreq), .cfg_l2_en(cfg_l2_en),
    .cfg_l4_en(cfg_l4_en), .cfg_src_chk(cfg_src_chk), .ts_event(ts_event)
  );

  always #10 clk = ~clk;

  int   errs = 0, nchk = 0;
  int   cnt, fidx, last_idx, flen;
  logic [7:0] frm [0:127];
  bit   done = 0;

  task automatic check_eq(string tag, int act, int exp);
    nchk++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic observe();
    if (ts_event) begin
      cnt++;
      fidx = last_idx;
    end
  endtask

  task automatic send(bit gaps);
    cnt = 0; fidx = -1; last_idx = -1;
    for (int i = 0; i < flen; i++) begin
      @(negedge clk); observe();
      in_valid = 1'b1; in_sof = (i == 0); in_data = frm[i]; last_idx = i;
      if (gaps && (i % 3 == 1)) begin
        @(negedge clk); observe();
        in_valid = 1'b0; in_sof = 1'b0; in_data = 8'hA5;
      end
    end
    @(negedge clk); observe();
    in_valid = 1'b0; in_sof = 1'b0;
    @(negedge clk); observe();
  endtask

  task automatic expect_fire(string tag, int idx);
    check_eq({tag, " count"}, cnt, 1);
    check_eq({tag, " index"}, fidx, idx);
  endtask

  task automatic expect_none(string tag);
    check_eq(tag, cnt, 0);
  endtask

  task automatic set_cfg(logic [1:0] m, logic l2, logic l4, logic sc, logic dq);
    cfg_mode = m; cfg_l2_en = l2; cfg_l4_en = l4; cfg_src_chk = sc; cfg_v1_dreq = dq;
  endtask

  task automatic fill_mac();
    for (int i = 0; i < 128; i++) frm[i] = 8'hEE;
    for (int i = 0; i < 12; i++) frm[i] = 8'(8'h10 + i);
  endtask

  task automatic build_l2(logic [3:0] msg, logic [3:0] ver);
    fill_mac();
    frm[12] = 8'h88; frm[13] = 8'hF7;
    frm[14] = {4'h0, msg}; frm[15] = {4'h0, ver};
    flen = 60;
  endtask

  // returns nothing; payload start = 14 + 4*ihl + 8
  task automatic build_udp(int ihl, logic [7:0] proto, logic [15:0] sp, logic [15:0] dp,
                           logic [3:0] msg, logic [3:0] ver, logic [7:0] ctrl);
    int ub, ps;
    fill_mac();
    frm[12] = 8'h08; frm[13] = 8'h00;
    frm[14] = {4'h4, 4'(ihl)};
    for (int i = 15; i < 14 + 4 * ihl; i++) frm[i] = 8'h00;
    frm[23] = proto;
    ub = 14 + 4 * ihl;
    frm[ub] = sp[15:8]; frm[ub+1] = sp[7:0]; frm[ub+2] = dp[15:8]; frm[ub+3] = dp[7:0];
    ps = ub + 8;
    frm[ps] = {4'h0, msg}; frm[ps+1] = {4'h0, ver};
    frm[ps+32] = ctrl;
    flen = ps + 40;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check_eq("R1 during reset", int'(ts_event), 0);
    rst = 1'b0;
    @(negedge clk);
    check_eq("R1 after reset", int'(ts_event), 0);
  endtask

  task automatic t_off();
    set_cfg(2'd0, 1, 1, 0, 0);
    build_l2(4'h0, 4'h2); send(0); expect_none("R2 off l2 event");
    build_udp(5, 8'd17, 16'd319, 16'd319, 4'h1, 4'h2, 8'h00); send(0); expect_none("R2 off udp event");
  endtask

  task automatic t_all();
    set_cfg(2'd3, 0, 0, 0, 0);
    fill_mac(); frm[12] = 8'h12; frm[13] = 8'h34; flen = 20;
    send(0); expect_fire("R3 all junk", 0);
    build_l2(4'hB, 4'h2); send(1); expect_fire("R3 all gapped", 0);
  endtask

  task automatic t_l2();
    set_cfg(2'd2, 1, 0, 0, 0);
    build_l2(4'h0, 4'h2); send(0); expect_fire("R4 l2 sync", 15);
    build_l2(4'h3, 4'h2); send(0); expect_fire("R4 l2 type3", 15);
    set_cfg(2'd2, 0, 1, 0, 0);
    build_l2(4'h0, 4'h2); send(0); expect_none("R4 l2 disabled");
  endtask

  task automatic t_l4();
    set_cfg(2'd2, 0, 1, 0, 0);
    build_udp(5, 8'd17, 16'd1000, 16'd319, 4'h1, 4'h2, 8'h00); send(0); expect_fire("R5 udp dreq", 43);
    set_cfg(2'd2, 1, 0, 0, 0);
    send(0); expect_none("R5 udp disabled");
  endtask

  task automatic t_ihl();
    set_cfg(2'd2, 0, 1, 0, 0);
    build_udp(7, 8'd17, 16'd319, 16'd319, 4'h0, 4'h2, 8'h00); send(0); expect_fire("R6 ihl7", 51);
    build_udp(15, 8'd17, 16'd319, 16'd319, 4'h2, 4'h2, 8'h00); send(0); expect_fire("R6 ihl15", 83);
  endtask

  task automatic t_src();
    set_cfg(2'd2, 0, 1, 1, 0);
    build_udp(5, 8'd17, 16'd319, 16'd319, 4'h0, 4'h2, 8'h00); send(0); expect_fire("R7 src match", 43);
    build_udp(5, 8'd17, 16'd1234, 16'd319, 4'h0, 4'h2, 8'h00); send(0); expect_none("R7 src mismatch");
    set_cfg(2'd2, 0, 1, 0, 0);
    send(0); expect_fire("R7 src unchecked", 43);
  endtask

  task automatic t_nonevent();
    set_cfg(2'd2, 1, 1, 0, 0);
    build_l2(4'hB, 4'h2); send(0); expect_none("R8 l2 announce");
    build_l2(4'h4, 4'h2); send(0); expect_none("R8 l2 type4");
    build_udp(5, 8'd17, 16'd319, 16'd319, 4'h0, 4'h1, 8'h00); send(0); expect_none("R8 udp ver1");
  endtask

  task automatic t_v1();
    set_cfg(2'd1, 1, 1, 0, 0);
    build_udp(5, 8'd17, 16'd319, 16'd319, 4'h0, 4'h1, 8'h00); send(0); expect_fire("R9 v1 sync", 74);
    build_udp(5, 8'd17, 16'd319, 16'd319, 4'h0, 4'h1, 8'h01); send(0); expect_none("R9 v1 dreq unselected");
    set_cfg(2'd1, 1, 1, 0, 1);
    send(0); expect_fire("R9 v1 dreq", 74);
    build_udp(6, 8'd17, 16'd319, 16'd319, 4'h0, 4'h1, 8'h01); send(1); expect_fire("R9 v1 dreq ihl6 gapped", 78);
    build_udp(5, 8'd17, 16'd319, 16'd319, 4'h0, 4'h2, 8'h01); send(0); expect_none("R9 v1 wrong version");
    build_l2(4'h1, 4'h1); frm[46] = 8'h01; send(0); expect_none("R9 v1 l2 frame");
  endtask

  task automatic t_gap();
    set_cfg(2'd2, 1, 1, 0, 0);
    build_l2(4'h1, 4'h2); send(1); expect_fire("R10 gapped l2", 15);
    send(0); expect_fire("R10 rearm next frame", 15);
    build_udp(5, 8'd17, 16'd319, 16'd319, 4'h0, 4'h2, 8'h00); send(1); expect_fire("R10 gapped udp", 43);
  endtask

  task automatic t_badport();
    set_cfg(2'd2, 0, 1, 0, 0);
    build_udp(5, 8'd17, 16'd319, 16'd320, 4'h0, 4'h2, 8'h00); send(0); expect_none("R11 dst 320");
    build_udp(5, 8'd6, 16'd319, 16'd319, 4'h0, 4'h2, 8'h00); send(0); expect_none("R11 proto tcp");
  endtask

  initial begin
    t_reset();
    t_off();
    t_all();
    t_l2();
    t_l4();
    t_ihl();
    t_src();
    t_nonevent();
    t_v1();
    t_gap();
    t_badport();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++; nchk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errs, nchk);
      $finish;
    end
  end

endmodule